// File: doc/BRIEF.md
# Windowed Watchdog Supervisor with Power-On Delay

This block supervises a processor. It combines a supply-good level with a windowed watchdog timer. From these it drives an active-low system reset and an active-high enable. The supply-good level is already compared and is synchronous to `clk`. The service input is asynchronous and passes through a synchroniser. A service request is recognised on its falling edge.

While supply-good is low, reset is held. Once supply-good returns, reset is held for a further power-on delay, and service requests are ignored during that delay. After the delay the block runs a repeating cycle: a closed window, then an open window. A service edge in the open window restarts the closed window. A service edge in the closed window, or no service edge before the open window ends, produces a reset pulse. After the pulse, a new closed window begins.

All durations are counted in `tick` pulses from an outside prescaler. A supply drop must last a set number of ticks before it counts as a failure. Once it counts, it overrides every timer state.

The state machine has five states, each with its own transitions:
- `S_DOWN`: supply failed. It goes to `S_POR` when the failure clears.
- `S_POR`: power-on delay. It goes to `S_CLOSED` when the delay expires.
- `S_CLOSED`: service is not allowed. An early service edge goes to `S_PULSE`. When the window expires, the machine goes to `S_OPEN`.
- `S_OPEN`: service is expected. A service edge goes to `S_CLOSED` and sets enable. When the window expires, the machine goes to `S_PULSE`.
- `S_PULSE`: reset pulse. It goes to `S_CLOSED` when the pulse time expires.

A filtered supply failure moves the machine from any state to `S_DOWN`.

Top module: `wwdg_supervisor`

## Requirements
- R1: After `rst_n` and while the filtered supply failure is active, `wd_rst_n` is 0 and `sys_en` is 0. A failure that is present at one clock edge shows as `wd_rst_n`=0 after the following edge.
- R2: The supply counts as failed only once `pwr_good` has been low for `GLITCH_TICKS` consecutive ticks. A shorter low period leaves `wd_rst_n` and `sys_en` unchanged. `pwr_good`=1 clears the failure at the next edge.
- R3: After the failure clears, `wd_rst_n` stays 0 for the power-on delay of TPOR ticks, where TPOR = `TCW`+`TOW`. Service edges during this delay have no effect, so `sys_en` is still 0 when the delay ends.
- R4: With `POR_QUARTER`=1, TPOR is (`TCW`+`TOW`)/4 ticks.
- R5: A service falling edge in the closed window drives `wd_rst_n` to 0 for `TWDR` ticks, after which a new closed window starts.
- R6: A service falling edge in the open window restarts the closed window with `wd_rst_n` held at 1.
- R7: If no service edge arrives, `wd_rst_n` is low for `TWDR` ticks after each closed+open window. The falling edges of `wd_rst_n` then repeat every `TCW`+`TOW`+`TWDR` ticks.
- R8: `sys_en` rises only on a correctly timed service edge in the open window. It falls with every watchdog reset pulse and every supply failure. `sys_en`=1 implies `wd_rst_n`=1.
- R9: `svc_in` passes through a two-flop synchroniser. Only a 1-to-0 transition is an event, and each such transition gives one event. A rising edge or a held low level gives none.
- R10: A filtered supply failure overrides any state, including the open window and the reset pulse. It clears all timers, so a full TPOR delay follows recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| tick | input | 1 | One-cycle time-base pulse from the prescaler |
| pwr_good | input | 1 | Compared supply level, 1 = supply above threshold |
| svc_in | input | 1 | Asynchronous service input, event on falling edge |
| wd_rst_n | output | 1 | Registered system reset, active low |
| sys_en | output | 1 | Registered system enable, active high |

## Verification
The bench serves the watchdog early, on time and not at all. It checks that an early edge produces a reset pulse instead of a restart, and that a design treating the closed window as open would keep reset high at that point. A service edge during the power-on delay must leave enable low afterwards; a design without the lockout would raise enable. The bench holds the service input low across a window boundary, which catches a design that counts the level or the rising edge. It also applies a supply dip shorter than the filter and a longer dip in the middle of a serviced cycle, which catches a missing filter or a failure that does not override the timer. A second instance with the quarter-delay variant is compared against its own model to confirm the shorter power-on delay.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;
    typedef enum logic [2:0] {
        S_DOWN   = 3'd0,
        S_POR    = 3'd1,
        S_CLOSED = 3'd2,
        S_OPEN   = 3'd3,
        S_PULSE  = 3'd4
    } wd_state_t;
endpackage

// File: rtl/wwdg_sync.sv
// Service-input synchroniser with falling-edge event extraction.
module wwdg_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic svc_in,
    output logic svc_fall
);
    logic [SYNC_STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[SYNC_STAGES-1:0], svc_in};
        end
    end

    // older sample high, newer sample low: one event per 1->0 transition
    assign svc_fall = pipe_q[SYNC_STAGES] & ~pipe_q[SYNC_STAGES-1];

    a_r9_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        svc_fall |=> !svc_fall);
endmodule

// File: rtl/wwdg_supply_filter.sv
// Declares a supply failure only after a run of low ticks.
module wwdg_supply_filter #(
    parameter int GLITCH_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwr_good,
    output logic supply_fail
);
    localparam int FW = $clog2(GLITCH_TICKS + 1);
    localparam logic [FW-1:0] LAST = FW'(GLITCH_TICKS - 1);

    logic [FW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q   <= '0;
            supply_fail <= 1'b1;
        end else if (pwr_good) begin
            low_cnt_q   <= '0;
            supply_fail <= 1'b0;
        end else if (tick) begin
            if (low_cnt_q == LAST) begin
                supply_fail <= 1'b1;
            end else begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
        end
    end

    a_r2_good_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |=> !supply_fail);
    a_r2_no_fail_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_fail && !tick) |=> !supply_fail);
endmodule

// File: rtl/wwdg_tick_timer.sv
// Tick counter shared by all timed states.
module wwdg_tick_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/wwdg_supervisor.sv
// Supply supervisor with windowed watchdog.
module wwdg_supervisor #(
    parameter int TCW          = 8,
    parameter int TOW          = 4,
    parameter int TWDR         = 2,
    parameter int GLITCH_TICKS = 3,
    parameter bit POR_QUARTER  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwr_good,
    input  logic svc_in,
    output logic wd_rst_n,
    output logic sys_en
);
    import wwdg_pkg::*;

    localparam int TWD   = TCW + TOW;
    localparam int TPOR  = POR_QUARTER ? (TWD / 4) : TWD;
    localparam int TMAX1 = (TPOR > TCW) ? TPOR : TCW;
    localparam int TMAX2 = (TOW > TWDR) ? TOW : TWDR;
    localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
    localparam int CW    = $clog2(TMAX + 1);

    localparam logic [CW-1:0] POR_END   = CW'(TPOR - 1);
    localparam logic [CW-1:0] CLOS_END  = CW'(TCW - 1);
    localparam logic [CW-1:0] OPEN_END  = CW'(TOW - 1);
    localparam logic [CW-1:0] PULSE_END = CW'(TWDR - 1);

    logic          svc_evt;
    logic          fail;
    logic          tmr_clr;
    logic [CW-1:0] tmr;
    wd_state_t     state_q, state_nx;

    wwdg_sync #(.SYNC_STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .svc_in  (svc_in),
        .svc_fall(svc_evt)
    );

    wwdg_supply_filter #(.GLITCH_TICKS(GLITCH_TICKS)) u_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .pwr_good   (pwr_good),
        .supply_fail(fail)
    );

    wwdg_tick_timer #(.CW(CW)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .tick (tick),
        .count(tmr)
    );

    // next-state decision
    always_comb begin
        state_nx = state_q;
        if (fail) begin
            state_nx = S_DOWN;
        end else begin
            unique case (state_q)
                S_DOWN:   state_nx = S_POR;
                S_POR:    if (tick && tmr == POR_END) state_nx = S_CLOSED;
                S_CLOSED: begin
                    if (svc_evt)                        state_nx = S_PULSE;
                    else if (tick && tmr == CLOS_END)   state_nx = S_OPEN;
                end
                S_OPEN: begin
                    if (svc_evt)                        state_nx = S_CLOSED;
                    else if (tick && tmr == OPEN_END)   state_nx = S_PULSE;
                end
                S_PULSE:  if (tick && tmr == PULSE_END) state_nx = S_CLOSED;
                default:  state_nx = S_DOWN;
            endcase
        end
    end

    // every state change, and the whole failed state, restarts the timer
    assign tmr_clr = (state_nx != state_q) || (state_q == S_DOWN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_DOWN;
        else        state_q <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_rst_n <= 1'b0;
            sys_en   <= 1'b0;
        end else begin
            wd_rst_n <= (state_nx == S_CLOSED) || (state_nx == S_OPEN);
            if (state_nx == S_DOWN || state_nx == S_POR || state_nx == S_PULSE)
                sys_en <= 1'b0;
            else if (state_q == S_OPEN && svc_evt)
                sys_en <= 1'b1;
        end
    end

    a_r1_fail_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (!wd_rst_n && !sys_en));
    a_r8_enable_implies_run: assert property (@(posedge clk) disable iff (!rst_n)
        sys_en |-> wd_rst_n);
    a_r3_por_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POR) |-> (!wd_rst_n && !sys_en));
    a_r5_early_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CLOSED && svc_evt && !fail) |=> (!wd_rst_n && !sys_en));
    a_r6_open_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OPEN && svc_evt && !fail) |=> (wd_rst_n && sys_en && state_q == S_CLOSED));
    a_r10_override: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (state_q == S_DOWN));
endmodule

// File: tb/wwdg_supervisor_test.sv
// Behavioural reference: phase number plus elapsed ticks.
module wwdg_ref #(
    parameter int TCW = 8, parameter int TOW = 4, parameter int TWDR = 2,
    parameter int GLITCH_TICKS = 3, parameter bit POR_QUARTER = 1'b0
) (
    input  logic clk, input logic rst_n, input logic tick,
    input  logic pwr_good, input logic svc_in,
    output logic exp_rst, output logic exp_en, output int phase
);
    // phase: 0 down, 1 power-on delay, 2 closed, 3 open, 4 pulse
    int por_len;
    int elapsed;
    int low_run;
    bit failed;
    bit h1, h2, h3;
    initial por_len = POR_QUARTER ? (TCW + TOW) / 4 : (TCW + TOW);

    always @(posedge clk or negedge rst_n) begin
        bit ev, f_old;
        int np;
        if (!rst_n) begin
            phase = 0; elapsed = 0; low_run = 0; failed = 1;
            h1 = 1; h2 = 1; h3 = 1; exp_rst = 0; exp_en = 0;
        end else begin
            ev = h3 && !h2;
            f_old = failed;
            h3 = h2; h2 = h1; h1 = svc_in;
            if (pwr_good) begin low_run = 0; failed = 0; end
            else if (tick) begin
                if (low_run == GLITCH_TICKS - 1) failed = 1; else low_run++;
            end
            np = phase;
            if (f_old) np = 0;
            else if (phase == 0) np = 1;
            else if (phase == 1) begin
                if (tick && elapsed + 1 == por_len) np = 2;
            end else if (phase == 2) begin
                if (ev) np = 4;
                else if (tick && elapsed + 1 == TCW) np = 3;
            end else if (phase == 3) begin
                if (ev) begin np = 2; exp_en = 1; end
                else if (tick && elapsed + 1 == TOW) np = 4;
            end else begin
                if (tick && elapsed + 1 == TWDR) np = 2;
            end
            if (np != phase || np == 0) elapsed = 0;
            else if (tick) elapsed++;
            phase = np;
            exp_rst = (phase == 2 || phase == 3);
            if (phase == 0 || phase == 1 || phase == 4) exp_en = 0;
        end
    end
endmodule

module wwdg_supervisor_test;
    localparam int TCW = 8, TOW = 4, TWDR = 2, GL = 3, TDIV = 3;

    logic clk = 0, rst_n = 0, tick = 0, pwr_good = 0, svc_in = 1;
    logic wd_rst_n, sys_en, q_rst_n, q_en;
    logic m_rst, m_en, mq_rst, mq_en;
    int   m_phase, mq_phase;
    int   total = 0, bad = 0, cyc = 0;
    int   fall_a = -1, fall_b = -1;
    logic prev_rst = 0;
    bit   done = 0;

    always #10 clk = ~clk;  // 50 MHz

    wwdg_supervisor #(.TCW(TCW), .TOW(TOW), .TWDR(TWDR), .GLITCH_TICKS(GL), .POR_QUARTER(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_good(pwr_good), .svc_in(svc_in),
        .wd_rst_n(wd_rst_n), .sys_en(sys_en));
    wwdg_supervisor #(.TCW(TCW), .TOW(TOW), .TWDR(TWDR), .GLITCH_TICKS(GL), .POR_QUARTER(1'b1)) uut_q (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_good(pwr_good), .svc_in(svc_in),
        .wd_rst_n(q_rst_n), .sys_en(q_en));
    wwdg_ref #(.TCW(TCW), .TOW(TOW), .TWDR(TWDR), .GLITCH_TICKS(GL), .POR_QUARTER(1'b0)) ref_m (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_good(pwr_good), .svc_in(svc_in),
        .exp_rst(m_rst), .exp_en(m_en), .phase(m_phase));
    wwdg_ref #(.TCW(TCW), .TOW(TOW), .TWDR(TWDR), .GLITCH_TICKS(GL), .POR_QUARTER(1'b1)) ref_q (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_good(pwr_good), .svc_in(svc_in),
        .exp_rst(mq_rst), .exp_en(mq_en), .phase(mq_phase));

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", req, cyc, act, exp);
        end
    endtask

    function automatic string req_of(input int p);
        case (p)
            0: return "R1";
            1: return "R3";
            2: return "R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    // tick generator, cycle counter, watchdog, per-cycle model comparison
    always @(negedge clk) begin
        cyc++;
        tick <= ((cyc % TDIV) == 0);
        if (rst_n && !done) begin
            chk(req_of(m_phase), wd_rst_n, m_rst);
            chk("R8", sys_en, m_en);
            chk("R4", q_rst_n, mq_rst);
            chk("R4", q_en, mq_en);
            if (prev_rst && !wd_rst_n) begin fall_a = fall_b; fall_b = cyc; end
            prev_rst = wd_rst_n;
        end
        if (cyc > 150000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_phase(input int p);
        @(negedge clk);
        while (m_phase != p) @(negedge clk);
    endtask

    task automatic service(input int low_len);
        svc_in = 0;
        cycles(low_len);
        svc_in = 1;
    endtask

    initial begin
        cycles(4);
        rst_n = 1;
        cycles(1);
        chk("R1", wd_rst_n, 1'b0);
        chk("R1", sys_en, 1'b0);
        cycles(20);
        chk("R1", wd_rst_n, 1'b0);

        // power-up: quarter delay finishes first; service in delay is ignored
        pwr_good = 1;
        cycles(8);
        service(3);
        cycles(9);
        chk("R4", q_rst_n, 1'b1);
        chk("R3", wd_rst_n, 1'b0);
        wait_phase(2);
        cycles(1);
        chk("R3", wd_rst_n, 1'b1);
        chk("R3", sys_en, 1'b0);

        // no service: square wave period
        cycles(100);
        total++;
        if (fall_b - fall_a != (TCW + TOW + TWDR) * TDIV) begin
            bad++;
            $display("FAIL R7: actual period=%0d expected=%0d", fall_b - fall_a, (TCW + TOW + TWDR) * TDIV);
        end

        // leave failure state with an open-window service
        wait_phase(3);
        cycles(2);
        service(2);
        cycles(4);
        chk("R6", wd_rst_n, 1'b1);
        chk("R8", sys_en, 1'b1);

        // service held low across a window boundary: only the falling edge counts
        wait_phase(3);
        cycles(1);
        svc_in = 0;
        cycles(20);
        svc_in = 1;
        cycles(5);
        chk("R9", wd_rst_n, 1'b1);
        chk("R9", sys_en, 1'b1);

        // early service in the closed window
        wait_phase(2);
        cycles(3);
        service(2);
        cycles(3);
        chk("R5", wd_rst_n, 1'b0);
        chk("R8", sys_en, 1'b0);

        // short supply dip under the filter length
        wait_phase(2);
        cycles(2);
        pwr_good = 0;
        cycles(4);
        pwr_good = 1;
        cycles(2);
        chk("R2", wd_rst_n, 1'b1);

        // get enabled, then a long dip in the open window
        wait_phase(3);
        cycles(1);
        service(2);
        wait_phase(3);
        cycles(1);
        pwr_good = 0;
        cycles(15);
        chk("R10", wd_rst_n, 1'b0);
        chk("R10", sys_en, 1'b0);
        pwr_good = 1;
        cycles(20);
        chk("R10", wd_rst_n, 1'b0);
        wait_phase(2);
        cycles(1);
        chk("R10", wd_rst_n, 1'b1);

        // dip during a reset pulse
        wait_phase(4);
        pwr_good = 0;
        cycles(14);
        chk("R1", wd_rst_n, 1'b0);
        pwr_good = 1;
        cycles(60);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule